// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block keeps wall-clock time and calendar date as packed BCD: century, year, month, day of month, day of week, hours, minutes and seconds, on a 24-hour clock. A free-running enable at the crystal rate (32.768 kHz by default) is divided down to one step per second. Each step moves the whole count forward, with every carry from seconds up to century handled in the same step. Day-of-month limits and leap years are taken into account.

Software sees a second copy of the count, the visible bank, through a small byte-wide register port. Reads are combinational and writes take effect on the clock edge. The visible bank normally follows the running count. A hold bit freezes it so that a multi-byte read is coherent. A load bit opens it for editing, and clearing the load bit moves the edited values into the running count in one step. The running count never pauses for either bit. Only the run/stop bit in the seconds byte can stop timekeeping.

The clock bank takes the upper eight offsets of a 2^ADDR_W byte window. The lower offsets read as zero.

Top module: `rtc_cal`

## Requirements
- R1: After reset the bank reads offset 8 = 20h, offset 9 = 80h, A = 00h, B = 00h, C = 01h, D = 01h, E = 01h and F = 00h. This is 2000-01-01, weekday 1, 00:00:00, with timekeeping stopped.
- R2: Bit 7 of offset 9 is the run/stop bit, and its reset value is 1. It can be written at any time. While it is 1, the second prescaler ignores input ticks and holds its partial count. On restart, counting continues from that partial count.
- R3: The seconds value advances by one after TICKS_PER_SEC enabled input ticks. Seconds and minutes wrap at 59 and hours wrap at 23, each wrap carrying into the next field in the same step.
- R4: When the hour wraps, day of week steps once in the range 01 to 07, wrapping from 07 to 01.
- R5: Months 04, 06, 09 and 11 end at day 30. Month 02 ends at day 29 when the BCD year is a multiple of 4 and at day 28 otherwise. All other months end at day 31. Past the last day, the date goes to 01 and the month advances.
- R6: Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00 and carries into the century. Century 39 wraps to 00.
- R7: Writing offset 8 with bit 6 = 1 (hold) freezes the visible bank at the count current at that write while the running count continues. The clock cycle after bit 6 is written back to 0, the visible bank shows the running count again.
- R8: Writing offset 8 with bit 7 = 1 (load) stops the visible bank following the count. Writes to offsets 9 to F then land in the visible bank and read back.
- R9: Writing offset 8 with bit 7 = 0 while load is set copies the visible bank into the running count and restarts the second prescaler at zero, so the next second passes TICKS_PER_SEC ticks later.
- R10: With load clear, writes to the time fields at offsets 9 to F are ignored. Only their run/stop bit lands. The century bits 5:0 of an offset 8 write land only when that write's bit 7 is 1.
- R11: Offsets 0 to 7 read 00h, and writes to them change nothing.
- R12: Field layout: offset 8 = {load, hold, century[5:0]}, 9 = {run/stop, sec[6:0]}, A = min[6:0], B = hour[5:0], C = weekday[2:0], D = date[5:0], E = month[4:0], F = year[7:0]. Unused upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle pulse at the crystal rate |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for regAddr |

## Verification
The assertions take it for granted that software only ever commits valid BCD values within each field's range. They also assume that a century value is written only together with the load bit. The range and weekday properties rely on both of these.

The stimulus writes deliberately out-of-range bytes only while load is set, to observe field masking. It overwrites them with valid values before every commit. Every sweep value loaded by the bench is computed in range: for example, the last day of each month for a leap and a non-leap year.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;
  localparam int FIELDS = 8;
  localparam int IDX_W  = $clog2(FIELDS);
  // field index = low offset bits inside the clock bank
  localparam int F_CEN  = 0;
  localparam int F_SEC  = 1;
  localparam int F_MIN  = 2;
  localparam int F_HR   = 3;
  localparam int F_DOW  = 4;
  localparam int F_DATE = 5;
  localparam int F_MON  = 6;
  localparam int F_YR   = 7;

  typedef logic [7:0] bcd8_t;
  typedef logic [FIELDS-1:0][7:0] calRegs_t;

  typedef struct packed {
    logic              secTick;
    logic              commit;
    logic              track;
    logic [FIELDS-1:0] fieldWr;
    logic [7:0]        wrByte;
  } calStrobe_t;

  // {yr, mon, date, dow, hr, min, sec, cen}
  localparam calRegs_t CAL_RESET = 64'h00_01_01_01_00_00_00_20;

  function automatic bcd8_t fieldMask(input int idx);
    case (idx)
      F_CEN:  return 8'h3F;
      F_SEC:  return 8'h7F;
      F_MIN:  return 8'h7F;
      F_HR:   return 8'h3F;
      F_DOW:  return 8'h07;
      F_DATE: return 8'h3F;
      F_MON:  return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bcd8_t bcdInc(input bcd8_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic isLeap(input bcd8_t yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic bcd8_t monthDays(input bcd8_t mon, input bcd8_t yr);
    case (mon)
      8'h02: return isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  function automatic calRegs_t calAdvance(input calRegs_t t);
    calRegs_t r;
    r = t;
    if (t[F_SEC] != 8'h59) r[F_SEC] = bcdInc(t[F_SEC]);
    else begin
      r[F_SEC] = 8'h00;
      if (t[F_MIN] != 8'h59) r[F_MIN] = bcdInc(t[F_MIN]);
      else begin
        r[F_MIN] = 8'h00;
        if (t[F_HR] != 8'h23) r[F_HR] = bcdInc(t[F_HR]);
        else begin
          r[F_HR]  = 8'h00;
          r[F_DOW] = (t[F_DOW] == 8'h07) ? 8'h01 : bcdInc(t[F_DOW]);
          if (t[F_DATE] != monthDays(t[F_MON], t[F_YR])) r[F_DATE] = bcdInc(t[F_DATE]);
          else begin
            r[F_DATE] = 8'h01;
            if (t[F_MON] != 8'h12) r[F_MON] = bcdInc(t[F_MON]);
            else begin
              r[F_MON] = 8'h01;
              if (t[F_YR] != 8'h99) r[F_YR] = bcdInc(t[F_YR]);
              else begin
                r[F_YR]  = 8'h00;
                r[F_CEN] = (t[F_CEN] == 8'h39) ? 8'h00 : bcdInc(t[F_CEN]);
              end
            end
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/rtc_cal_ctrl.sv
`timescale 1ns/1ps
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  input  calRegs_t          extRegs,
  output logic [7:0]        rdData,
  output calStrobe_t        strobes,
  output logic              wBit,
  output logic              rBit,
  output logic              oscStop
);
  localparam int CNT_W = $clog2(TICKS_PER_SEC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] preCnt;
  logic             bankHit;
  logic [IDX_W-1:0] fieldIdx;
  logic             ctlWr;
  logic             secWr;
  logic             tickLive;

  assign bankHit  = &regAddr[ADDR_W-1:IDX_W];
  assign fieldIdx = regAddr[IDX_W-1:0];
  assign ctlWr    = regWr && bankHit && (fieldIdx == IDX_W'(F_CEN));
  assign secWr    = regWr && bankHit && (fieldIdx == IDX_W'(F_SEC));
  assign tickLive = tickEn && !oscStop;

  always_comb begin
    strobes         = '0;
    strobes.wrByte  = wrData;
    strobes.track   = !wBit && !rBit;
    strobes.commit  = ctlWr && wBit && !wrData[7];
    strobes.secTick = tickLive && (preCnt == CNT_LAST);
    for (int i = 0; i < FIELDS; i++) begin
      if (regWr && bankHit && (fieldIdx == IDX_W'(i))) begin
        // century lands only with load set in the same byte; time fields need load already set
        if (i == F_CEN) strobes.fieldWr[i] = wrData[7];
        else            strobes.fieldWr[i] = wBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wBit    <= 1'b0;
      rBit    <= 1'b0;
      oscStop <= 1'b1;
    end else begin
      if (ctlWr) begin
        wBit <= wrData[7];
        rBit <= wrData[6];
      end
      if (secWr) oscStop <= wrData[7];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               preCnt <= '0;
    else if (strobes.commit) preCnt <= '0;
    else if (tickLive)       preCnt <= (preCnt == CNT_LAST) ? '0 : preCnt + 1'b1;
  end

  always_comb begin
    rdData = 8'h00;
    if (bankHit) begin
      if (fieldIdx == IDX_W'(F_CEN))      rdData = {wBit, rBit, 6'b0} | extRegs[F_CEN];
      else if (fieldIdx == IDX_W'(F_SEC)) rdData = {oscStop, 7'b0} | extRegs[F_SEC];
      else                                rdData = extRegs[fieldIdx];
    end
  end
endmodule

// File: rtl/rtc_cal_dp.sv
`timescale 1ns/1ps
module rtc_cal_dp
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strobes,
  output calRegs_t   intRegs,
  output calRegs_t   extRegs
);
  calRegs_t intNext;

  always_comb begin
    if (strobes.commit)       intNext = extRegs;
    else if (strobes.secTick) intNext = calAdvance(intRegs);
    else                      intNext = intRegs;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intRegs <= CAL_RESET;
    else       intRegs <= intNext;
  end

  for (genvar g = 0; g < FIELDS; g++) begin : gExt
    bcd8_t extQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   extQ <= CAL_RESET[g];
      else if (strobes.fieldWr[g]) extQ <= strobes.wrByte & fieldMask(g);
      else if (strobes.track)      extQ <= intNext[g];
    end
    assign extRegs[g] = extQ;
  end
endmodule

// File: rtl/rtc_cal.sv
`timescale 1ns/1ps
module rtc_cal
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);
  calStrobe_t strobes;
  calRegs_t   intRegs;
  calRegs_t   extRegs;
  logic       wBit;
  logic       rBit;
  logic       oscStop;

  rtc_cal_ctrl #(.TICKS_PER_SEC(TICKS_PER_SEC), .ADDR_W(ADDR_W)) ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr), .regAddr(regAddr),
    .wrData(wrData), .extRegs(extRegs), .rdData(rdData), .strobes(strobes),
    .wBit(wBit), .rBit(rBit), .oscStop(oscStop)
  );

  rtc_cal_dp dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .intRegs(intRegs), .extRegs(extRegs)
  );
endmodule

// File: rtl/rtc_cal_chk.sv
`timescale 1ns/1ps
module rtc_cal_chk
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic              loadBitIn,
  input logic [7:0]        rdData,
  input logic              wBit,
  input logic              rBit,
  input logic              oscStop,
  input logic              commit,
  input calRegs_t          intRegs,
  input calRegs_t          extRegs
);
  logic inBank;
  logic cenLoad;
  assign inBank  = &regAddr[ADDR_W-1:IDX_W];
  assign cenLoad = regWr && inBank && (regAddr[IDX_W-1:0] == '0) && loadBitIn;

  assert_stop_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (oscStop && !commit) |=> $stable(intRegs));

  assert_time_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (intRegs[F_SEC] <= 8'h59) && (intRegs[F_MIN] <= 8'h59) && (intRegs[F_HR] <= 8'h23));

  assert_weekday_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intRegs[F_DOW] >= 8'h01) && (intRegs[F_DOW] <= 8'h07));

  assert_view_tracks_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wBit && !rBit && !cenLoad) |=> (extRegs == intRegs));

  assert_view_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rBit && !wBit && !cenLoad) |=> $stable(extRegs));

  assert_commit_copies_R9: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> (intRegs == $past(extRegs)));

  assert_low_bank_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !inBank |-> (rdData == 8'h00));
endmodule

bind rtc_cal rtc_cal_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .loadBitIn(wrData[7]),
  .rdData(rdData), .wBit(wBit), .rBit(rBit), .oscStop(oscStop),
  .commit(strobes.commit), .intRegs(intRegs), .extRegs(extRegs)
);

// File: tb/rtc_cal_test.sv
`timescale 1ns/1ps
module rtc_cal_test;
  localparam int TPS = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWr = 1'b0;
  logic [3:0] regAddr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  always #2.5 clk = ~clk;

  rtc_cal #(.TICKS_PER_SEC(TPS), .ADDR_W(4)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr),
    .regAddr(regAddr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int lastDay(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; wrData = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); regAddr = a; #1; d = rdData;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] got;
    rd(a, got);
    chk(tag, got, exp);
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic setTime(input int cen, input int yr, input int mon, input int dat,
                         input int dow, input int hr, input int mn, input int sc);
    wr(4'h8, 8'h80 | bcd(cen));
    wr(4'hF, bcd(yr));
    wr(4'hE, bcd(mon));
    wr(4'hD, bcd(dat));
    wr(4'hC, bcd(dow));
    wr(4'hB, bcd(hr));
    wr(4'hA, bcd(mn));
    wr(4'h9, bcd(sc));
    wr(4'h8, bcd(cen));
  endtask

  task automatic expTime(input string tag, input int cen, input int yr, input int mon,
                         input int dat, input int dow, input int hr, input int mn, input int sc);
    rdChk(tag, 4'h8, bcd(cen));
    rdChk(tag, 4'hF, bcd(yr));
    rdChk(tag, 4'hE, bcd(mon));
    rdChk(tag, 4'hD, bcd(dat));
    rdChk(tag, 4'hC, bcd(dow));
    rdChk(tag, 4'hB, bcd(hr));
    rdChk(tag, 4'hA, bcd(mn));
    rdChk(tag, 4'h9, bcd(sc));
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired got=running exp=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 / R12: reset contents and layout
    rdChk("R1 ctl", 4'h8, 8'h20);
    rdChk("R1 R12 sec+stop", 4'h9, 8'h80);
    rdChk("R1 min", 4'hA, 8'h00);
    rdChk("R1 hr", 4'hB, 8'h00);
    rdChk("R1 dow", 4'hC, 8'h01);
    rdChk("R1 date", 4'hD, 8'h01);
    rdChk("R1 mon", 4'hE, 8'h01);
    rdChk("R1 yr", 4'hF, 8'h00);

    // R2: stopped after reset, then run, stop mid-second, resume
    ticks(3 * TPS);
    rdChk("R2 stopped", 4'h9, 8'h80);
    wr(4'h9, 8'h00);
    ticks(TPS - 1);
    rdChk("R2 R3 partial", 4'h9, 8'h00);
    ticks(1);
    rdChk("R2 R3 one second", 4'h9, 8'h01);
    ticks(2);
    wr(4'h9, 8'h80);
    ticks(10);
    rdChk("R2 hold while stopped", 4'h9, 8'h81);
    wr(4'h9, 8'h00);
    ticks(2);
    rdChk("R2 partial kept", 4'h9, 8'h02);

    // R10: writes ignored with load clear
    wr(4'hA, 8'h33);
    rdChk("R10 min ignored", 4'hA, 8'h00);
    wr(4'h8, 8'h15);
    rdChk("R10 century ignored", 4'h8, 8'h20);

    // R11: low offsets
    wr(4'h3, 8'hFF);
    rdChk("R11 low read", 4'h3, 8'h00);
    rdChk("R11 low read 7", 4'h7, 8'h00);
    rdChk("R11 no side effect", 4'h9, 8'h02);

    // R8 / R12: load mode, masks
    wr(4'h8, 8'hA0);
    rdChk("R8 ctl load", 4'h8, 8'hA0);
    wr(4'hC, 8'hFF);
    rdChk("R12 dow mask", 4'hC, 8'h07);
    wr(4'hB, 8'hFF);
    rdChk("R12 hr mask", 4'hB, 8'h3F);
    wr(4'hA, 8'h45);
    rdChk("R8 min written", 4'hA, 8'h45);
    ticks(3 * TPS);
    rdChk("R8 view halted", 4'h9, 8'h02);
    wr(4'hC, 8'h03);
    wr(4'hB, 8'h12);
    wr(4'h9, 8'h30);
    wr(4'h8, 8'h20);
    // R9: commit
    rdChk("R9 hr", 4'hB, 8'h12);
    rdChk("R9 min", 4'hA, 8'h45);
    rdChk("R9 sec", 4'h9, 8'h30);
    rdChk("R9 dow", 4'hC, 8'h03);
    ticks(TPS - 1);
    rdChk("R9 prescaler restarted", 4'h9, 8'h30);
    ticks(1);
    rdChk("R9 first second", 4'h9, 8'h31);

    // R7: hold
    wr(4'h8, 8'h60);
    rdChk("R7 ctl hold", 4'h8, 8'h60);
    ticks(2 * TPS);
    rdChk("R7 frozen", 4'h9, 8'h31);
    rdChk("R7 frozen min", 4'hA, 8'h45);
    wr(4'h8, 8'h20);
    rdChk("R7 resumed", 4'h9, 8'h33);

    // R4: weekday wrap
    setTime(20, 24, 5, 15, 7, 23, 59, 59);
    ticks(TPS);
    expTime("R4 weekday wrap", 20, 24, 5, 16, 1, 0, 0, 0);

    // R6: year and century
    setTime(19, 99, 12, 31, 2, 23, 59, 59);
    ticks(TPS);
    expTime("R6 century carry", 20, 0, 1, 1, 3, 0, 0, 0);
    setTime(39, 99, 12, 31, 5, 23, 59, 59);
    ticks(TPS);
    expTime("R6 century wrap", 0, 0, 1, 1, 6, 0, 0, 0);

    // R5: month-end sweep over a plain year, a leap year and year 00
    for (int yi = 0; yi < 3; yi++) begin
      int y;
      y = (yi == 0) ? 23 : (yi == 1) ? 24 : 0;
      for (int m = 1; m <= 12; m++) begin
        int d;
        d = lastDay(m, y);
        setTime(20, y, m, d - 1, 3, 23, 59, 59);
        ticks(TPS);
        expTime("R5 before month end", 20, y, m, d, 4, 0, 0, 0);
        setTime(20, y, m, d, 3, 23, 59, 59);
        ticks(TPS);
        expTime("R5 month end", 20, (m == 12) ? y + 1 : y, (m == 12) ? 1 : m + 1, 1, 4, 0, 0, 0);
      end
    end

    // R3: second-by-second sweep across two hours and a leap-day midnight
    setTime(20, 24, 2, 28, 3, 22, 0, 0);
    for (int k = 1; k <= 7300; k++) begin
      int tot;
      ticks(TPS);
      tot = (22 * 3600 + k) % 86400;
      rdChk("R3 sec", 4'h9, bcd(tot % 60));
      rdChk("R3 min", 4'hA, bcd((tot / 60) % 60));
      rdChk("R3 hr", 4'hB, bcd(tot / 3600));
    end
    rdChk("R3 R5 leap day", 4'hD, 8'h29);
    rdChk("R3 R4 weekday", 4'hC, 8'h04);

    report();
    $finish;
  end
endmodule